// File: doc/BRIEF.md
# Timestamped Sample Channel FIFO

This block is the receive buffer of one converter channel. Each time the converter signals a finished conversion, the block builds a 32-bit word from the 14-bit sample and the current value of a free-running 17-bit cycle counter. It then writes that word into a four-entry first-in first-out store. A register-read port removes the oldest word, and a 3-bit output always shows how many words are held.

Service requests take one of two paths, selected by a per-channel mode input. With the mode set, the channel raises a DMA request for as long as words are waiting. With the mode clear, the block's event pulses go to an interrupt vector instead. Four one-cycle event pulses are always available: full, empty, overflow and underflow. A synchronous soft-reset input empties the store without stopping the timestamp counter.

Top module: `tsfifo_chan`

## Requirements
- R1: A stored word holds the sample in bits [13:0] and the timestamp in bits [31:14]. The timestamp is the 17-bit counter value in the push cycle, zero-extended, so bit 31 is always 0. The counter is 0 in the first cycle after `rst` is released, increments every clock and wraps from 0x1FFFF to 0.
- R2: Words leave in the order they were accepted. `rd_data` is registered: it takes the popped word in the cycle after the pop edge and holds it until the next pop.
- R3: `fill_level` is the number of stored words (0 to 4). It changes in the cycle after the push or pop edge.
- R4: A push while four words are held is discarded, even if a pop occurs in the same cycle. The contents are not changed, and `ev_overflow` pulses high for one cycle.
- R5: A pop while the store is empty loads zero into `rd_data` and leaves the level unchanged. `ev_underflow` pulses high for one cycle.
- R6: A push and a pop in the same cycle at a level of 1, 2 or 3 leave the level unchanged.
- R7: `ev_full` pulses for one cycle when the level first reads 4. `ev_empty` pulses for one cycle when the level first reads 0 after being non-zero.
- R8: `dma_req` is high exactly while `dma_mode` is 1 and the level is non-zero. It drops in the cycle after the edge that pops the last word.
- R9: `irq_evt` carries the event pulses while `dma_mode` is 0, with bit 0 overflow, bit 1 underflow, bit 2 full and bit 3 empty. It is all zero while `dma_mode` is 1.
- R10: `soft_rst` takes priority over a push or pop in the same cycle. It empties the store, sets the level and `rd_data` to 0 and clears the event pulses. It does not disturb the timestamp counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears everything including the counter |
| soft_rst | input | 1 | Synchronous store clear; the counter keeps running |
| conv_strobe | input | 1 | Conversion done: push one word |
| sample_in | input | 14 | Converted sample |
| rd_pop | input | 1 | Read strobe: pop the oldest word |
| dma_mode | input | 1 | 1 selects the DMA request, 0 selects the interrupt vector |
| rd_data | output | 32 | Last popped word |
| fill_level | output | 3 | Number of stored words |
| dma_req | output | 1 | DMA service request |
| ev_full | output | 1 | Store became full |
| ev_empty | output | 1 | Store became empty |
| ev_overflow | output | 1 | Push was discarded |
| ev_underflow | output | 1 | Pop found nothing |
| irq_evt | output | 4 | Event pulses routed to interrupt logic |

## Verification
`fill_level`, `rd_data` and the four event pulses are registered. Each is due exactly one cycle after the clock edge that samples the push, pop or soft-reset stimulus. `dma_req` and `irq_evt` follow the level and the event pulses combinationally, with the current mode, so they are due in that same cycle. The bench applies stimulus at the falling edge, advances one rising edge, and then compares every output 1 ns later against a queue model it updates for that edge. Every sample point therefore lands one register stage after its cause.

// File: rtl/tsfifo_pkg.sv
package tsfifo_pkg;

    localparam int SAMPLE_W = 14;
    localparam int STAMP_W  = 18;
    localparam int CTR_W    = 17;
    localparam int WORD_W   = SAMPLE_W + STAMP_W;
    localparam int DEPTH    = 4;
    localparam int LVL_W    = $clog2(DEPTH + 1);
    localparam int EVT_W    = 4;

    // Stored word: timestamp field above the sample field.
    typedef struct packed {
        logic [STAMP_W-1:0]  stamp;
        logic [SAMPLE_W-1:0] sample;
    } word_t;

    // Event pulses; the last member lands in bit 0.
    typedef struct packed {
        logic empty;
        logic full;
        logic underflow;
        logic overflow;
    } evt_t;

    function automatic word_t pack_word(input logic [SAMPLE_W-1:0] smp,
                                        input logic [CTR_W-1:0]    ts);
        word_t w;
        w.sample = smp;
        w.stamp  = {{(STAMP_W-CTR_W){1'b0}}, ts};
        return w;
    endfunction

endpackage

// File: rtl/tsf_stamp_ctr.sv
module tsf_stamp_ctr #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] stamp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stamp <= '0;
        end else begin
            stamp <= stamp + 1'b1;
        end
    end

endmodule

// File: rtl/tsf_store.sv
module tsf_store #(
    parameter  int DEPTH  = 4,
    parameter  int WORD_W = 32,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic              pop,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] head,
    output logic [LVL_W-1:0]  level,
    output logic [LVL_W-1:0]  level_nxt,
    output logic              pop_ok
);

    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              push_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    // Acceptance is judged on the level before this edge.
    assign push_ok = push && (level != LVL_FULL);
    assign pop_ok  = pop  && (level != '0);
    assign head    = mem[rd_ptr];

    always_comb begin
        unique case ({push_ok, pop_ok})
            2'b10:   level_nxt = level + 1'b1;
            2'b01:   level_nxt = level - 1'b1;
            default: level_nxt = level;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            level <= level_nxt;
            if (push_ok) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= bump(rd_ptr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !rst && !clr) begin
            mem[wr_ptr] <= wdata;
        end
    end

endmodule

// File: rtl/tsf_events.sv
module tsf_events
    import tsfifo_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] level_nxt,
    output evt_t          ev
);

    localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ev <= '0;
        end else begin
            ev.overflow  <= push && (level == LVL_FULL);
            ev.underflow <= pop && (level == '0);
            ev.full      <= (level_nxt == LVL_FULL) && (level != LVL_FULL);
            ev.empty     <= (level_nxt == '0) && (level != '0);
        end
    end

endmodule

// File: rtl/tsfifo_chan.sv
module tsfifo_chan
    import tsfifo_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                soft_rst,
    input  logic                conv_strobe,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                rd_pop,
    input  logic                dma_mode,
    output logic [WORD_W-1:0]   rd_data,
    output logic [LVL_W-1:0]    fill_level,
    output logic                dma_req,
    output logic                ev_full,
    output logic                ev_empty,
    output logic                ev_overflow,
    output logic                ev_underflow,
    output logic [EVT_W-1:0]    irq_evt
);

    logic [CTR_W-1:0]  stamp;
    word_t             wr_word;
    logic [WORD_W-1:0] head;
    logic [LVL_W-1:0]  level_nxt;
    logic              pop_ok;
    evt_t              ev;

    tsf_stamp_ctr #(.W(CTR_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .stamp (stamp)
    );

    assign wr_word = pack_word(sample_in, stamp);

    tsf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clr       (soft_rst),
        .push      (conv_strobe),
        .pop       (rd_pop),
        .wdata     (wr_word),
        .head      (head),
        .level     (fill_level),
        .level_nxt (level_nxt),
        .pop_ok    (pop_ok)
    );

    tsf_events #(.DEPTH(DEPTH)) u_evt (
        .clk       (clk),
        .rst       (rst),
        .clr       (soft_rst),
        .push      (conv_strobe),
        .pop       (rd_pop),
        .level     (fill_level),
        .level_nxt (level_nxt),
        .ev        (ev)
    );

    // Read register: an empty pop returns zero.
    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            rd_data <= '0;
        end else if (rd_pop) begin
            rd_data <= pop_ok ? head : '0;
        end
    end

    assign dma_req      = dma_mode && (fill_level != '0);
    assign irq_evt      = dma_mode ? '0 : EVT_W'(ev);
    assign ev_full      = ev.full;
    assign ev_empty     = ev.empty;
    assign ev_overflow  = ev.overflow;
    assign ev_underflow = ev.underflow;

endmodule

// File: rtl/tsfifo_chan_chk.sv
module tsfifo_chan_chk
    import tsfifo_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                soft_rst,
    input logic                conv_strobe,
    input logic [SAMPLE_W-1:0] sample_in,
    input logic                rd_pop,
    input logic                dma_mode,
    input logic [WORD_W-1:0]   rd_data,
    input logic [LVL_W-1:0]    fill_level,
    input logic                dma_req,
    input logic                ev_full,
    input logic                ev_empty,
    input logic                ev_overflow,
    input logic                ev_underflow,
    input logic [EVT_W-1:0]    irq_evt
);

    localparam logic [LVL_W-1:0] FULL_L = LVL_W'(DEPTH);

    AST_STAMP_MSB_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[WORD_W-1] == 1'b0); // R1

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill_level <= FULL_L); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (conv_strobe && !rd_pop && !soft_rst && fill_level == FULL_L)
        |=> (ev_overflow && fill_level == FULL_L)); // R4

    AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && !conv_strobe && !soft_rst && fill_level == '0)
        |=> (ev_underflow && rd_data == '0 && fill_level == '0)); // R5

    AST_BALANCED_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (conv_strobe && rd_pop && !soft_rst && fill_level != '0 && fill_level != FULL_L)
        |=> $stable(fill_level)); // R6

    AST_EDGE_EVENTS: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_full, ev_empty}) && $onehot0({ev_overflow, ev_underflow})); // R7

    AST_DMA_DROP: assert property (@(posedge clk) disable iff (rst)
        (rd_pop && !conv_strobe && !soft_rst && fill_level == LVL_W'(1))
        |=> !dma_req); // R8

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        dma_mode |-> (irq_evt == '0)); // R9

    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (fill_level == '0 && rd_data == '0 && !ev_full && !ev_overflow)); // R10

endmodule

bind tsfifo_chan tsfifo_chan_chk u_chk (.*);

// File: tb/tsfifo_chan_tb.sv
`timescale 1ns/1ps
module tsfifo_chan_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        soft_rst;
    logic        conv_strobe;
    logic [13:0] sample_in;
    logic        rd_pop;
    logic        dma_mode;
    logic [31:0] rd_data;
    logic [2:0]  fill_level;
    logic        dma_req;
    logic        ev_full, ev_empty, ev_overflow, ev_underflow;
    logic [3:0]  irq_evt;

    always #4 clk = ~clk;

    tsfifo_chan u_dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .conv_strobe(conv_strobe),
        .sample_in(sample_in), .rd_pop(rd_pop), .dma_mode(dma_mode),
        .rd_data(rd_data), .fill_level(fill_level), .dma_req(dma_req),
        .ev_full(ev_full), .ev_empty(ev_empty), .ev_overflow(ev_overflow),
        .ev_underflow(ev_underflow), .irq_evt(irq_evt)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    logic [31:0] q[$];
    logic [31:0] m_rd;
    logic [16:0] m_ctr;
    logic        m_ovf, m_udf, m_full, m_empty;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_word(logic [13:0] s, logic [16:0] t);
        return {1'b0, t, s};
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic check_all(bit mode);
        chk("R3 fill_level", 32'(fill_level), 32'(q.size()));
        chk("R2 rd_data", rd_data, m_rd);
        chk("R4 ev_overflow", 32'(ev_overflow), 32'(m_ovf));
        chk("R5 ev_underflow", 32'(ev_underflow), 32'(m_udf));
        chk("R7 ev_full", 32'(ev_full), 32'(m_full));
        chk("R7 ev_empty", 32'(ev_empty), 32'(m_empty));
        chk("R8 dma_req", 32'(dma_req), 32'(mode && q.size() != 0));
        chk("R9 irq_evt", 32'(irq_evt),
            mode ? 32'd0 : 32'({m_empty, m_full, m_udf, m_ovf}));
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(bit push, logic [13:0] s, bit pop, bit srst, bit mode);
        int lvl;
        conv_strobe = push; sample_in = s; rd_pop = pop;
        soft_rst = srst; dma_mode = mode;
        lvl = q.size();
        if (srst) begin
            q.delete();
            m_rd = '0;
            {m_ovf, m_udf, m_full, m_empty} = '0;
        end else begin
            m_ovf = push && lvl == 4;
            m_udf = pop && lvl == 0;
            if (pop) m_rd = (lvl > 0) ? q.pop_front() : 32'd0;
            if (push && lvl < 4) q.push_back(mk_word(s, m_ctr));
            m_full  = (q.size() == 4) && (lvl != 4);
            m_empty = (q.size() == 0) && (lvl != 0);
        end
        m_ctr++;
        @(posedge clk);
        #1;
        check_all(mode);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [16:0] t0;
        bit          mode;
        void'($urandom(32'd2024));
        rst = 1'b1; soft_rst = 0; conv_strobe = 0; sample_in = '0;
        rd_pop = 0; dma_mode = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_ctr = '0; m_rd = '0;
        {m_ovf, m_udf, m_full, m_empty} = '0;
        #1;
        chk("R3 reset level", 32'(fill_level), 32'd0);
        chk("R2 reset rd_data", rd_data, 32'd0);
        chk("R8 reset dma_req", 32'(dma_req), 32'd0);

        // Fill to four, then overflow (R4, R7).
        t0 = m_ctr;
        step(1, 14'h0A1, 0, 0, 1);
        step(1, 14'h1B2, 0, 0, 1);
        step(1, 14'h2C3, 0, 0, 1);
        step(1, 14'h3FFF, 0, 0, 1);
        step(1, 14'h155, 0, 0, 1);
        // Push and pop together at full: push still dropped.
        step(1, 14'h0AA, 1, 0, 1);
        chk("R1 sample field", 32'(rd_data[13:0]), 32'h0A1);
        chk("R1 stamp field", 32'(rd_data[31:14]), 32'(t0));
        chk("R4 push at full dropped", 32'(fill_level), 32'd3);

        // Drain: DMA request falls after last pop (R8).
        step(0, 0, 1, 0, 1);
        step(0, 0, 1, 0, 1);
        step(0, 0, 1, 0, 1);
        chk("R8 dma_req low after last pop", 32'(dma_req), 32'd0);
        chk("R2 last word order", 32'(rd_data[13:0]), 32'h3FFF);

        // Underflow (R5), interrupt mode.
        step(0, 0, 1, 0, 0);
        chk("R5 empty pop data", rd_data, 32'd0);

        // Balanced push/pop (R6).
        step(1, 14'h011, 0, 0, 0);
        step(1, 14'h022, 0, 0, 0);
        step(1, 14'h033, 1, 0, 0);
        chk("R6 level held", 32'(fill_level), 32'd2);

        // Soft reset with a simultaneous push (R10).
        step(1, 14'h044, 0, 1, 0);
        chk("R10 level cleared", 32'(fill_level), 32'd0);
        t0 = m_ctr;
        step(1, 14'h055, 0, 0, 1);
        step(0, 0, 1, 0, 1);
        chk("R10 counter kept running", 32'(rd_data[30:14]), 32'(t0));

        // Constrained random traffic.
        mode = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if (i % 200 == 0) mode = $urandom_range(0, 1);
            step($urandom_range(0, 99) < 55, 14'($urandom),
                 $urandom_range(0, 99) < 45, $urandom_range(0, 99) < 2, mode);
        end

        // Counter wrap (R1).
        step(0, 0, 0, 1, 1);
        while (m_ctr != 17'h1FFFF) step(0, 0, 0, 0, 1);
        step(1, 14'h123, 0, 0, 1);
        step(1, 14'h321, 0, 0, 1);
        step(0, 0, 1, 0, 1);
        chk("R1 stamp at max", 32'(rd_data[30:14]), 32'h1FFFF);
        step(0, 0, 1, 0, 1);
        chk("R1 stamp wrapped", 32'(rd_data[30:14]), 32'd0);
        chk("R1 msb zero", 32'(rd_data[31]), 32'd0);

        done = 1;
        summary();
        $finish;
    end

endmodule